// File: doc/BRIEF.md
# Zero-Data Analog Mute Detector

This block decides when the analog output stage of a two-channel audio converter should be clamped. Once per frame it takes a one-cycle sample strobe together with the current 16-bit left and right input words, the 4-bit output routing code and the two attenuator levels. From these it judges whether the frame is silent. A saturating run counter measures how long the silence has lasted. When the run reaches 2^RUN_LOG2 frames (16384 by default, about 0.37 s at 44.1 kHz), the mute output rises.

Silence is judged against the routing. Only the input channels that actually reach an output are inspected. A routing that silences both outputs counts as silent. So do two attenuators that both sit at level 0, whatever the input data. After reset the block runs a resynchronisation phase: the outputs are reported as muted until the RESYNC_EDGES-th frame strobe after reset release, and the mute output is held high for that whole time.

Top module: `zero_mute_detector`

## Requirements
- R1: While reset is low, and in the first cycle after it, `out_muted` and `zero_mute` are both 1.
- R2: After reset release, `out_muted` stays 1 through the first 8 frame strobes and falls at the 9th (RESYNC_EDGES). It changes only in the cycle after a strobe.
- R3: `zero_mute` is 1 whenever `out_muted` is 1. Frames seen during resynchronisation do not advance the silence run.
- R4: `zero_mute` rises at the strobe that completes 2^RUN_LOG2 consecutive silent frames, counted from the first strobe after resynchronisation ends. It never rises except in the cycle after a strobe.
- R5: The routing code holds the left-output source in bits [1:0] and the right-output source in bits [3:2]. Each source field is encoded as 0 = silence, 1 = left input, 2 = right input, 3 = half-sum of both inputs. An input channel is watched if any output field selects it directly or selects the half-sum. A frame is silent when every watched channel's word is all zeros. An unwatched channel's data has no effect.
- R6: When both source fields are 0, every frame is silent, whatever the data.
- R7: When both attenuator levels are 0, every frame is silent. A single zero attenuator level has no effect.
- R8: A non-silent frame clears the run. `zero_mute` falls in the cycle after that strobe and does not change between strobes.
- R9: The run saturates at 2^RUN_LOG2. During arbitrarily long silence `zero_mute` stays 1 and the count never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per frame, taken from the rising frame-clock edge |
| left_word | input | DATA_W | Left input sample, two's complement |
| right_word | input | DATA_W | Right input sample, two's complement |
| mode_code | input | 4 | Output routing code (see R5) |
| atten_l | input | ATT_W | Left attenuator level, 0 = full cut |
| atten_r | input | ATT_W | Right attenuator level, 0 = full cut |
| zero_mute | output | 1 | Analog mute request |
| out_muted | output | 1 | High during the post-reset resynchronisation phase |

## Verification
Two events can land on the same strobe. One is the strobe that ends resynchronisation; the other is the first strobe whose frame would count toward or break a silence run. They meet when frames are already silent as the init phase closes. The bench provokes this by feeding all-zero data right through the resync strobes. It then checks that the run count starts only at the strobe after the 9th, and that the flag is not early by even one frame. The saturation limit and a clearing frame also coincide, when a nonzero word arrives right after a long silence; the bench expects the flag to drop in the cycle after that strobe.

// File: rtl/zero_mute_detector.sv
module zero_mute_detector #(
  parameter int DATA_W       = 16,
  parameter int ATT_W        = 8,
  parameter int RUN_LOG2     = 14,
  parameter int RESYNC_EDGES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] left_word,
  input  logic [DATA_W-1:0] right_word,
  input  logic [3:0]        mode_code,
  input  logic [ATT_W-1:0]  atten_l,
  input  logic [ATT_W-1:0]  atten_r,
  output logic              zero_mute,
  output logic              out_muted
);
  localparam int CNT_W  = RUN_LOG2 + 1;
  localparam int SYNC_W = $clog2(RESYNC_EDGES + 1);
  localparam logic [CNT_W-1:0]  RUN_FULL  = CNT_W'(1) << RUN_LOG2;
  localparam logic [SYNC_W-1:0] SYNC_DONE = SYNC_W'(RESYNC_EDGES);

  logic [CNT_W-1:0]  run_cnt;
  logic [SYNC_W-1:0] sync_cnt;

  wire [1:0] src_l = mode_code[1:0];
  wire [1:0] src_r = mode_code[3:2];

  wire watch_l = src_l[0] | src_r[0];
  wire watch_r = src_l[1] | src_r[1];
  wire route_silent = (src_l == 2'd0) && (src_r == 2'd0);
  wire atten_floor  = (atten_l == '0) && (atten_r == '0);
  wire data_quiet   = (!watch_l || left_word == '0) && (!watch_r || right_word == '0);
  wire frame_silent = route_silent | atten_floor | data_quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sync_cnt <= '0;
    else if (frame_stb && sync_cnt != SYNC_DONE)
      sync_cnt <= sync_cnt + 1'b1;
  end

  assign out_muted = (sync_cnt != SYNC_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_cnt <= '0;
    else if (frame_stb && !out_muted) begin
      if (!frame_silent)
        run_cnt <= '0;
      else if (run_cnt != RUN_FULL)
        run_cnt <= run_cnt + 1'b1;
    end
  end

  assign zero_mute = out_muted | (run_cnt == RUN_FULL);

  assert_init_holds_mute_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_muted |-> zero_mute);

  assert_release_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_muted) |-> $past(frame_stb));

  assert_rise_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_mute) |-> $past(frame_stb));

  assert_hold_between_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(zero_mute));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_FULL);
endmodule

// File: tb/zero_mute_detector_bench.sv
module zero_mute_detector_bench;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int LOG2 = 4;
  localparam int FULL = 1 << LOG2;
  localparam int SYNC = 9;

  logic clk = 0;
  logic rst_n = 0;
  logic frame_stb = 0;
  logic [DW-1:0] left_word = '0, right_word = '0;
  logic [3:0] mode_code = 4'b1001;
  logic [AW-1:0] atten_l = 8'hFF, atten_r = 8'hFF;
  logic zero_mute, out_muted;

  int checks = 0, fails = 0, exp_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  zero_mute_detector #(.DATA_W(DW), .ATT_W(AW), .RUN_LOG2(LOG2), .RESYNC_EDGES(SYNC)) u_zero_mute_detector (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .left_word(left_word), .right_word(right_word),
    .mode_code(mode_code), .atten_l(atten_l), .atten_r(atten_r),
    .zero_mute(zero_mute), .out_muted(out_muted));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d: got %b expected %b (t=%0t)", tag, mode_code, act, exp, $time);
    end
  endtask

  function automatic bit silent_model(input logic [3:0] m, input logic [DW-1:0] l, input logic [DW-1:0] r,
                                      input logic [AW-1:0] al, input logic [AW-1:0] ar);
    bit use_l = (m[1:0] == 2'd1) || (m[1:0] == 2'd3) || (m[3:2] == 2'd1) || (m[3:2] == 2'd3);
    bit use_r = (m[1:0] == 2'd2) || (m[1:0] == 2'd3) || (m[3:2] == 2'd2) || (m[3:2] == 2'd3);
    bit off = (m == 4'd0);
    return off || (al == 0 && ar == 0) || ((!use_l || l == 0) && (!use_r || r == 0));
  endfunction

  task automatic frame(input string tag, input logic [DW-1:0] l, input logic [DW-1:0] r);
    @(negedge clk);
    left_word = l; right_word = r; frame_stb = 1;
    @(negedge clk);
    frame_stb = 0;
    if (silent_model(mode_code, l, r, atten_l, atten_r))
      exp_cnt = (exp_cnt < FULL) ? exp_cnt + 1 : FULL;
    else
      exp_cnt = 0;
    check(tag, zero_mute, exp_cnt == FULL);
    check({tag, "/R2"}, out_muted, 1'b0);
    @(negedge clk);
    check({tag, "/R8"}, zero_mute, exp_cnt == FULL);
  endtask

  task automatic do_reset(input logic [DW-1:0] init_data);
    @(negedge clk);
    rst_n = 0;
    atten_l = 8'hFF; atten_r = 8'hFF;
    @(negedge clk);
    check("R1 reset out_muted", out_muted, 1'b1);
    check("R1 reset zero_mute", zero_mute, 1'b1);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", out_muted & zero_mute, 1'b1);
    for (int k = 1; k <= SYNC; k++) begin
      @(negedge clk);
      left_word = init_data; right_word = init_data; frame_stb = 1;
      @(negedge clk);
      frame_stb = 0;
      check("R2 resync count", out_muted, k < SYNC);
      if (k < SYNC) check("R3 mute during init", zero_mute, 1'b1);
      else check("R3 no run during init", zero_mute, 1'b0);
    end
    exp_cnt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int m = 0; m < 16; m++) begin
      mode_code = m[3:0];
      do_reset(16'h0000);
      for (int i = 0; i < FULL + 2; i++) frame("R5 left zero right busy", 16'h0000, 16'h8000);
      for (int i = 0; i < FULL + 2; i++) frame("R5 right zero left busy", 16'h0001, 16'h0000);
      for (int i = 0; i < FULL + 4; i++) frame("R9 long silence", 16'h0000, 16'h0000);
      frame("R8 clear after silence", 16'h0100, 16'h0100);
      frame("R8 clear again", 16'h0000, 16'hFFFF);
      atten_l = 8'h00;
      for (int i = 0; i < 3; i++) frame("R7 single attenuator zero", 16'h7FFF, 16'h7FFF);
      atten_r = 8'h00;
      for (int i = 0; i < FULL + 1; i++) frame("R7 both attenuators zero", 16'h7FFF, 16'h8001);
      atten_l = 8'h10;
      frame("R7 attenuator lifted", 16'h7FFF, 16'h8001);
      atten_l = 8'hFF; atten_r = 8'hFF;
      if (m == 0)
        for (int i = 0; i < 2; i++) frame("R6 routing silences both", 16'h1234, 16'h4321);
      for (int i = 0; i < FULL; i++) frame("R4 exact run length", 16'h0000, 16'h0000);
    end
    mode_code = 4'b1001;
    do_reset(16'h0000);
    for (int i = 0; i < FULL; i++) frame("R4 run after silent init", 16'h0000, 16'h0000);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule